// File: doc/BRIEF.md
# Two-Way Instruction Fetch Cache

This block is a read-only instruction cache between a processor's fetch port and a burst-read port of external memory. It stores 8 KB as two ways, each with 256 lines of 16 bytes. A fetch that finds its line resident gets its 32-bit word back in the same cycle, with no external traffic. A fetch that misses stalls the processor and sends one line-aligned request for a fixed four-word block, which is sized so that one memory row stays open for the whole transfer. The block then writes the line into the way that a per-set least-recently-used pointer chooses.

The processor drives `cpu_req` and `cpu_addr` and holds both until `cpu_ready` is high. When the fill finishes, the line becomes valid and the stalled fetch completes as an ordinary hit in the next cycle. A synchronous `inv_all` input discards every line at once, for example after new code has been loaded into external memory.

Top module: `fetch_cache2w`

## Requirements
- R1: After reset, `cpu_ready` is high while no fetch is pending, `mem_req` is low, and no line is valid, so the first fetch to any address misses.
- R2: A fetch whose line is valid in either way returns, in the same cycle, the memory word at `cpu_addr` on `cpu_rdata` with `cpu_ready` high, and causes no memory request.
- R3: On a miss, `cpu_ready` is low in the request cycle. In the next cycle `mem_req` rises with `mem_addr` equal to `cpu_addr` with bits [3:0] cleared. Both stay unchanged until a cycle in which `mem_gnt` is high.
- R4: After the grant, the fill takes exactly four `mem_rvalid` beats. Beat k carries the word at line base + 4k and is stored as word k of the line.
- R5: A line becomes valid only on its fourth beat. `cpu_ready` stays low through the whole fill and rises in the cycle after the fourth beat, returning the requested word.
- R6: Byte address bits [3:2] select the word, bits [11:4] the set and bits [31:12] the tag. Two lines with the same set and different tags are resident at the same time, one in each way.
- R7: Each set has a pointer that names the way to replace, and it names way 0 after reset. A hit or fill on way w sets the pointer to the other way. A miss replaces the way the pointer names.
- R8: `inv_all` high at a clock edge clears every valid bit, so every later fetch misses until its line is filled again.
- R9: A memory request is raised only for a miss, so the number of bursts equals the number of misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| inv_all | input | 1 | Invalidate every line at this clock edge |
| cpu_req | input | 1 | Fetch request |
| cpu_addr | input | 32 | Fetch byte address |
| cpu_ready | output | 1 | High when the fetch completes in this cycle |
| cpu_rdata | output | 32 | Fetched instruction word |
| mem_req | output | 1 | Block read request, held until granted |
| mem_addr | output | 32 | Line-aligned block address |
| mem_gnt | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | A read beat is present |
| mem_rdata | input | 32 | Read beat data |

## Verification
The assertions assume that the processor keeps `cpu_addr` steady while a fetch is stalled. They also assume that the memory side sends `mem_rvalid` only after a grant, sends exactly four beats per grant, and never sends a beat while a request is still waiting for its grant. The bench's memory responder follows this protocol: it grants after seeing the request and then sends the four beats in order with irregular gaps. The bench changes `cpu_addr` only on a cycle in which `cpu_ready` was high. It asserts `inv_all` only while no fetch is in flight.

// File: rtl/icache_pkg.sv
package icache_pkg;
  localparam int NUM_WAYS = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_FILL = 2'd2
  } fill_st_e;
endpackage

// File: rtl/icache_rst_sync.sv
module icache_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/icache_tag_way.sv
module icache_tag_way #(
  parameter int TAG_W    = 20,
  parameter int SET_BITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inv_all,
  input  logic [SET_BITS-1:0] lk_set,
  input  logic [TAG_W-1:0]    lk_tag,
  output logic                lk_hit,
  input  logic                clr_en,
  input  logic [SET_BITS-1:0] clr_set,
  input  logic                fill_en,
  input  logic [SET_BITS-1:0] fill_set,
  input  logic [TAG_W-1:0]    fill_tag
);
  localparam int SETS = 1 << SET_BITS;

  logic [SETS-1:0]  valid_q, valid_d;
  logic [TAG_W-1:0] tag_q [SETS];

  // Next state of the valid vector: invalidate-all wins over any per-line update.
  always_comb begin
    valid_d = valid_q;
    if (clr_en)  valid_d[clr_set]  = 1'b0;
    if (fill_en) valid_d[fill_set] = 1'b1;
    if (inv_all) valid_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  // Tag storage carries no reset; the valid bit guards it.
  always_ff @(posedge clk) begin
    if (fill_en) tag_q[fill_set] <= fill_tag;
  end

  assign lk_hit = valid_q[lk_set] && (tag_q[lk_set] == lk_tag);
endmodule

// File: rtl/icache_data_way.sv
module icache_data_way #(
  parameter int WORD_W   = 32,
  parameter int SET_BITS = 8,
  parameter int WPL_BITS = 2
) (
  input  logic                clk,
  input  logic [SET_BITS-1:0] rd_set,
  input  logic [WPL_BITS-1:0] rd_word,
  output logic [WORD_W-1:0]   rd_data,
  input  logic                wr_en,
  input  logic [SET_BITS-1:0] wr_set,
  input  logic [WPL_BITS-1:0] wr_word,
  input  logic [WORD_W-1:0]   wr_data
);
  localparam int DEPTH = 1 << (SET_BITS + WPL_BITS);

  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[{wr_set, wr_word}] <= wr_data;
  end

  assign rd_data = mem_q[{rd_set, rd_word}];
endmodule

// File: rtl/icache_lru.sv
module icache_lru #(
  parameter int SET_BITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SET_BITS-1:0] rd_set,
  output logic                victim_way,
  input  logic                upd_en,
  input  logic [SET_BITS-1:0] upd_set,
  input  logic                upd_way
);
  localparam int SETS = 1 << SET_BITS;

  logic [SETS-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (upd_en) ptr_d[upd_set] = ~upd_way;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign victim_way = ptr_q[rd_set];
endmodule

// File: rtl/icache_fill_ctrl.sv
module icache_fill_ctrl
  import icache_pkg::*;
#(
  parameter int TAG_W    = 20,
  parameter int SET_BITS = 8,
  parameter int WPL_BITS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_req,
  input  logic                lk_hit,
  input  logic [SET_BITS-1:0] lk_set,
  input  logic [TAG_W-1:0]    lk_tag,
  input  logic                victim_way,
  input  logic                mem_gnt,
  input  logic                mem_rvalid,
  output logic                idle,
  output logic                miss_start,
  output logic                mem_req,
  output logic [SET_BITS-1:0] fill_set,
  output logic [TAG_W-1:0]    fill_tag,
  output logic                fill_way,
  output logic [WPL_BITS-1:0] fill_word,
  output logic                word_we,
  output logic                commit
);
  localparam logic [WPL_BITS-1:0] LAST_BEAT = '1;

  fill_st_e            state_q, state_d;
  logic [WPL_BITS-1:0] beat_q, beat_d;
  logic [SET_BITS-1:0] set_q;
  logic [TAG_W-1:0]    tag_q;
  logic                way_q;

  always_comb begin
    idle       = (state_q == ST_IDLE);
    miss_start = idle && cpu_req && !lk_hit;
    mem_req    = (state_q == ST_REQ);
    word_we    = (state_q == ST_FILL) && mem_rvalid;
    commit     = word_we && (beat_q == LAST_BEAT);

    state_d = state_q;
    beat_d  = beat_q;
    unique case (state_q)
      ST_IDLE: if (miss_start) state_d = ST_REQ;
      ST_REQ: begin
        if (mem_gnt) begin
          state_d = ST_FILL;
          beat_d  = '0;
        end
      end
      ST_FILL: begin
        if (word_we) beat_d = beat_q + 1'b1;
        if (commit)  state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
    end
  end

  // Miss target captured once, with an explicit enable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q <= '0;
      tag_q <= '0;
      way_q <= 1'b0;
    end else if (miss_start) begin
      set_q <= lk_set;
      tag_q <= lk_tag;
      way_q <= victim_way;
    end
  end

  assign fill_set  = set_q;
  assign fill_tag  = tag_q;
  assign fill_way  = way_q;
  assign fill_word = beat_q;
endmodule

// File: rtl/fetch_cache2w.sv
module fetch_cache2w
  import icache_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int WORD_W   = 32,
  parameter int SET_BITS = 8,
  parameter int WPL      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inv_all,
  input  logic              cpu_req,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_ready,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata
);
  localparam int WPL_BITS = $clog2(WPL);
  localparam int BYTE_BITS = $clog2(WORD_W / 8);
  localparam int OFF_BITS = WPL_BITS + BYTE_BITS;
  localparam int TAG_W    = ADDR_W - SET_BITS - OFF_BITS;

  logic                rst_n_i;
  logic [SET_BITS-1:0] lk_set;
  logic [TAG_W-1:0]    lk_tag;
  logic [WPL_BITS-1:0] lk_word;
  logic [NUM_WAYS-1:0] hit_vec;
  logic [WORD_W-1:0]   way_rdata [NUM_WAYS];
  logic                lk_hit, hit_way, victim_way;
  logic                idle, miss_start, word_we, commit;
  logic [SET_BITS-1:0] fill_set;
  logic [TAG_W-1:0]    fill_tag;
  logic                fill_way;
  logic [WPL_BITS-1:0] fill_word;
  logic                lru_upd_en, lru_upd_way;
  logic [SET_BITS-1:0] lru_upd_set;
  logic [BYTE_BITS-1:0] unused_byte_sel;

  icache_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_i)
  );

  assign lk_word         = cpu_addr[BYTE_BITS +: WPL_BITS];
  assign lk_set          = cpu_addr[OFF_BITS +: SET_BITS];
  assign lk_tag          = cpu_addr[ADDR_W-1 -: TAG_W];
  assign unused_byte_sel = cpu_addr[BYTE_BITS-1:0];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    icache_tag_way #(
      .TAG_W    (TAG_W),
      .SET_BITS (SET_BITS)
    ) u_tag (
      .clk      (clk),
      .rst_n    (rst_n_i),
      .inv_all  (inv_all),
      .lk_set   (lk_set),
      .lk_tag   (lk_tag),
      .lk_hit   (hit_vec[w]),
      .clr_en   (miss_start && (victim_way == 1'(w))),
      .clr_set  (lk_set),
      .fill_en  (commit && (fill_way == 1'(w))),
      .fill_set (fill_set),
      .fill_tag (fill_tag)
    );

    icache_data_way #(
      .WORD_W   (WORD_W),
      .SET_BITS (SET_BITS),
      .WPL_BITS (WPL_BITS)
    ) u_data (
      .clk     (clk),
      .rd_set  (lk_set),
      .rd_word (lk_word),
      .rd_data (way_rdata[w]),
      .wr_en   (word_we && (fill_way == 1'(w))),
      .wr_set  (fill_set),
      .wr_word (fill_word),
      .wr_data (mem_rdata)
    );
  end

  assign lk_hit  = |hit_vec;
  assign hit_way = hit_vec[1];

  icache_lru #(
    .SET_BITS (SET_BITS)
  ) u_lru (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .rd_set     (lk_set),
    .victim_way (victim_way),
    .upd_en     (lru_upd_en),
    .upd_set    (lru_upd_set),
    .upd_way    (lru_upd_way)
  );

  icache_fill_ctrl #(
    .TAG_W    (TAG_W),
    .SET_BITS (SET_BITS),
    .WPL_BITS (WPL_BITS)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .cpu_req    (cpu_req),
    .lk_hit     (lk_hit),
    .lk_set     (lk_set),
    .lk_tag     (lk_tag),
    .victim_way (victim_way),
    .mem_gnt    (mem_gnt),
    .mem_rvalid (mem_rvalid),
    .idle       (idle),
    .miss_start (miss_start),
    .mem_req    (mem_req),
    .fill_set   (fill_set),
    .fill_tag   (fill_tag),
    .fill_way   (fill_way),
    .fill_word  (fill_word),
    .word_we    (word_we),
    .commit     (commit)
  );

  // Recency update: fill completion has priority over a lookup hit (they never coincide).
  always_comb begin
    lru_upd_en  = commit || (idle && cpu_req && lk_hit);
    lru_upd_set = commit ? fill_set : lk_set;
    lru_upd_way = commit ? fill_way : hit_way;
  end

  assign cpu_ready = idle && !(cpu_req && !lk_hit);
  assign cpu_rdata = lk_hit ? way_rdata[hit_way] : '0;
  assign mem_addr  = {fill_tag, fill_set, {OFF_BITS{1'b0}}};
endmodule

// File: rtl/fetch_cache2w_chk.sv
module fetch_cache2w_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_req,
  input logic [31:0] cpu_addr,
  input logic        cpu_ready,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic        mem_gnt,
  input logic        mem_rvalid
);
  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

  // R3
  req_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[3:0] == 4'h0 && mem_addr[31:4] == cpu_addr[31:4]));

  // R5
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cpu_ready);

  // R9
  req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(cpu_req && !cpu_ready));

  // R2
  hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_ready) |=> !mem_req);

  // R4
  beat_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rvalid |-> !mem_req);
endmodule

bind fetch_cache2w fetch_cache2w_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_req    (cpu_req),
  .cpu_addr   (cpu_addr),
  .cpu_ready  (cpu_ready),
  .mem_req    (mem_req),
  .mem_addr   (mem_addr),
  .mem_gnt    (mem_gnt),
  .mem_rvalid (mem_rvalid)
);

// File: tb/fetch_cache2w_tb.sv
module fetch_cache2w_tb;
  logic        clk = 1'b0;
  logic        rst_n, inv_all, cpu_req, cpu_ready, mem_req, mem_gnt, mem_rvalid;
  logic [31:0] cpu_addr, cpu_rdata, mem_addr, mem_rdata;

  always #4 clk = ~clk;  // 125 MHz

  fetch_cache2w u_dut (
    .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
    .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  int n_vec = 0, n_bad = 0, cyc = 0, nreq = 0, nmiss = 0, last_edge = 0;
  bit done = 1'b0;
  logic [31:0] req_q[$];

  // Reference model state
  bit          mv [2][256];
  logic [19:0] mt [2][256];
  bit          ml [256];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] memf(input logic [31:0] a);
    return ({a[31:2], 2'b00} * 32'h0001_0003) ^ 32'h5A5A_1234;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  // Memory responder: grant, then four ascending beats with irregular gaps.
  initial begin
    mem_gnt = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_req === 1'b1) begin
        logic [31:0] base;
        base = mem_addr;
        req_q.push_back(mem_addr);
        nreq++;
        repeat (nreq % 3) @(negedge clk);
        mem_gnt = 1'b1;
        @(negedge clk);
        mem_gnt = 1'b0;
        for (int b = 0; b < 4; b++) begin
          repeat ((b + nreq) % 2) @(negedge clk);
          mem_rvalid = 1'b1;
          mem_rdata  = memf(base + 32'(4 * b));
          if (b == 3) last_edge = cyc + 1;
          @(negedge clk);
          mem_rvalid = 1'b0;
          mem_rdata  = '0;
        end
      end
    end
  end

  task automatic flush_all();
    @(negedge clk);
    cpu_req = 1'b0;
    inv_all = 1'b1;
    @(negedge clk);
    inv_all = 1'b0;
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 256; s++) mv[w][s] = 1'b0;
  endtask

  task automatic access(input logic [31:0] a, input string req);
    int          s, hw, victim, start, k;
    logic [19:0] t;
    logic [31:0] got;
    s = int'(a[11:4]);
    t = a[31:12];
    hw = -1;
    for (int w = 0; w < 2; w++)
      if (mv[w][s] && mt[w][s] == t) hw = w;
    @(negedge clk);
    cpu_req  = 1'b1;
    cpu_addr = a;
    #1;
    if (hw >= 0) begin
      chk(cpu_ready === 1'b1, req, "expected hit, ready", 32'(cpu_ready), 32'd1);
      chk(cpu_rdata === memf(a), "R2", "hit data", cpu_rdata, memf(a));
      chk(mem_req === 1'b0, "R2", "no request on hit", 32'(mem_req), 32'd0);
      ml[s] = (hw == 0);
    end else begin
      victim = ml[s] ? 1 : 0;
      start  = nreq;
      k      = 0;
      chk(cpu_ready === 1'b0, req, "expected miss, ready", 32'(cpu_ready), 32'd0);
      while (cpu_ready !== 1'b1 && k < 100) begin
        @(negedge clk);
        #1;
        k++;
        if (mem_req === 1'b1)
          chk(mem_addr === {a[31:4], 4'h0}, "R3", "request address", mem_addr, {a[31:4], 4'h0});
      end
      chk(k < 100, "R5", "fill completion", 32'(k), 32'd0);
      chk(cyc == last_edge, "R5", "ready cycle after fourth beat", 32'(cyc), 32'(last_edge));
      chk(cpu_rdata === memf(a), "R4", "filled word", cpu_rdata, memf(a));
      chk(nreq == start + 1, "R9", "one burst per miss", 32'(nreq), 32'(start + 1));
      got = (req_q.size() > 0) ? req_q.pop_front() : 32'hDEAD_BEEF;
      chk(got === {a[31:4], 4'h0}, "R3", "line-aligned address", got, {a[31:4], 4'h0});
      mv[victim][s] = 1'b1;
      mt[victim][s] = t;
      ml[s] = (victim == 0);
      nmiss++;
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] lcg, a;
    rst_n = 1'b0; inv_all = 1'b0; cpu_req = 1'b0; cpu_addr = '0;
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 256; s++) begin
        mv[w][s] = 1'b0; mt[w][s] = '0;
      end
    for (int s = 0; s < 256; s++) ml[s] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(cpu_ready === 1'b1, "R1", "idle ready", 32'(cpu_ready), 32'd1);
    chk(mem_req === 1'b0, "R1", "idle request", 32'(mem_req), 32'd0);

    // Cold miss, then the other words of the same line.
    access(32'h0000_1050, "R1");
    access(32'h0000_1054, "R4");
    access(32'h0000_1058, "R4");
    access(32'h0000_105C, "R4");
    // Same set, second tag: both ways resident.
    access(32'h0000_2054, "R6");
    access(32'h0000_1050, "R6");
    access(32'h0000_2058, "R6");
    // Replacement order within set 5.
    access(32'h0000_3058, "R7");
    access(32'h0000_2050, "R7");
    access(32'h0000_1050, "R7");
    access(32'h0000_3050, "R7");
    // Address extremes: set 255 with all-ones tag, set 0 with zero tag.
    access(32'hFFFF_FFFC, "R6");
    access(32'hFFFF_FFF0, "R6");
    access(32'h0000_000C, "R6");
    access(32'h0000_0000, "R6");
    // Invalidate all.
    flush_all();
    access(32'h0000_0000, "R8");
    access(32'h0000_2058, "R8");
    access(32'h0000_0004, "R2");

    // Pseudo-random walk over a small pool of tags, sets and words.
    lcg = 32'h1234_5678;
    for (int i = 0; i < 300; i++) begin
      int tg, st, wd;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      tg = int'(lcg[26:24]) % 5;
      st = (lcg[20:19] == 2'd0) ? 0 : (lcg[20:19] == 2'd1) ? 5 : 255;
      wd = int'(lcg[13:12]);
      a = (32'(tg) << 12) | (32'(st) << 4) | (32'(wd) << 2);
      if (i % 97 == 96) flush_all();
      access(a, "R7");
    end

    @(negedge clk);
    cpu_req = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(nreq == nmiss, "R9", "total bursts vs misses", 32'(nreq), 32'(nmiss));
    chk(mem_req === 1'b0, "R1", "quiet at end", 32'(mem_req), 32'd0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule